// File: doc/BRIEF.md
# GPIO Pad Configuration and Data Register Bank

This block holds the configuration and data state for a bank of general-purpose I/O pads. Each pin owns two word registers on a simple synchronous register bus. The control word selects the pin function, the bias network, the drive strength and whether the output driver is on. The data word carries the value the pad drives and shows the level the pad sees.

Writes are taken on the rising clock edge whenever `wrEn` is high. Reads are combinational from `addr` and the current register state. The per-pin fields are presented as flat output vectors, with pin `p` occupying slice `p`, so pad cells and the function router can connect to them directly. Each pad input level passes through a two-stage synchronizer before it reaches the data word.

Top module: `gpio_pad_regfile`

## Requirements
- R1: Pin p's control word is at word address 2p and its data word is at 2p+1. `rdData` shows the addressed word in the same cycle, and a write with `wrEn` high takes effect at the next rising edge.
- R2: Control bits [10:8] hold a 3-bit function selector that drives `funcSel[3p+2:3p]`. Value 0 means plain GPIO, and any other value names an alternate function.
- R3: Control bits [2:1] hold a 2-bit bias code that drives `biasSel[2p+1:2p]`, encoded 0 = no pull, 1 = pull-down, 2 = bus keeper, 3 = pull-up.
- R4: Control bits [6:4] hold a 3-bit drive code that drives `driveCode[3p+2:3p]`. The strength in mA is 2 × (code + 1), so codes 0 to 7 give 2 to 16 mA.
- R5: Control bit 0 is the output enable and drives `outEn[p]`. When it is 0 the pin is an input and its driver is off.
- R6: Data-word bit 1 is a read/write output value that drives `outData[p]`.
- R7: Data-word bit 0 is read-only and shows `padIn[p]` two rising edges after the pad level is sampled, whether or not the output is enabled.
- R8: Writing data-word bit 0 has no effect. Control bits 3, 7 and 11 to 31 read as zero, and so do data-word bits 2 to 31.
- R9: A read of any address at or above 2 × NUM_PINS returns zero, and a write to such an address changes nothing.
- R10: After reset every pin has function 0, pull-down bias, drive code 0, output disabled, output value 0 and a synchronized input of 0.
- R11: A write to one pin's register leaves every other pin's fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` |
| padIn | input | NUM_PINS | Raw pad input levels |
| funcSel | output | 3*NUM_PINS | Function selector per pin |
| biasSel | output | 2*NUM_PINS | Bias code per pin |
| driveCode | output | 3*NUM_PINS | Drive-strength code per pin |
| outEn | output | NUM_PINS | Output enable per pin |
| outData | output | NUM_PINS | Output value per pin |

## Verification
The bench builds the block with its default parameters: four pins, an 8-bit address and a 32-bit data word. With these values, address 7 is the last mapped word and address 8 is the first unmapped one, and the large unmapped range above it can be reached by both random and directed accesses. Four pins is enough to show that writes to neighbouring pins leave each other alone, and the bench sweeps every bias code and every drive code on one pin.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int PIN_IDX_W = 8;
  localparam int FUNC_W    = 3;
  localparam int BIAS_W    = 2;
  localparam int DRV_W     = 3;
  localparam int OE_BIT    = 0;
  localparam int BIAS_LSB  = 1;
  localparam int DRV_LSB   = 4;
  localparam int FUNC_LSB  = 8;
  localparam int IN_BIT    = 0;
  localparam int OUT_BIT   = 1;
  localparam logic [BIAS_W-1:0] BIAS_RESET = 2'd1;

  typedef struct packed {
    logic                 wrCtl;
    logic                 wrIo;
    logic                 selIo;
    logic                 hit;
    logic [PIN_IDX_W-1:0] pin;
  } padStrobe_t;
endpackage

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output padStrobe_t        strb
);
  localparam int IDX_W = ADDR_W - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

  logic [IDX_W-1:0] idx;
  logic             hit;

  assign idx = addr[ADDR_W-1:1];
  assign hit = (idx <= LAST_IDX);

  always_comb begin
    strb.hit   = hit;
    strb.selIo = addr[0];
    strb.pin   = PIN_IDX_W'(idx);
    strb.wrCtl = wrEn && hit && !addr[0];
    strb.wrIo  = wrEn && hit && addr[0];
  end
endmodule

// File: rtl/gpio_pad_datapath.sv
module gpio_pad_datapath
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  padStrobe_t               strb,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [NUM_PINS-1:0]      padIn,
  output logic [DATA_W-1:0]        rdData,
  output logic [FUNC_W*NUM_PINS-1:0] funcSel,
  output logic [BIAS_W*NUM_PINS-1:0] biasSel,
  output logic [DRV_W*NUM_PINS-1:0]  driveCode,
  output logic [NUM_PINS-1:0]      outEn,
  output logic [NUM_PINS-1:0]      outData
);
  localparam int PSEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [FUNC_W-1:0] funcQ [NUM_PINS];
  logic [BIAS_W-1:0] biasQ [NUM_PINS];
  logic [DRV_W-1:0]  drvQ  [NUM_PINS];
  logic [NUM_PINS-1:0] oeQ, outQ, syncA, syncB;
  logic [PSEL_W-1:0] pinSel;

  assign pinSel = strb.pin[PSEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic mine;
    assign mine = (strb.pin == PIN_IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        funcQ[g] <= '0;
        biasQ[g] <= BIAS_RESET;
        drvQ[g]  <= '0;
        oeQ[g]   <= 1'b0;
        outQ[g]  <= 1'b0;
      end else begin
        if (strb.wrCtl && mine) begin
          funcQ[g] <= wrData[FUNC_LSB +: FUNC_W];
          biasQ[g] <= wrData[BIAS_LSB +: BIAS_W];
          drvQ[g]  <= wrData[DRV_LSB +: DRV_W];
          oeQ[g]   <= wrData[OE_BIT];
        end
        if (strb.wrIo && mine) begin
          outQ[g] <= wrData[OUT_BIT];
        end
      end
    end

    assign funcSel[g*FUNC_W +: FUNC_W]   = funcQ[g];
    assign biasSel[g*BIAS_W +: BIAS_W]   = biasQ[g];
    assign driveCode[g*DRV_W +: DRV_W]   = drvQ[g];
  end

  assign outEn   = oeQ;
  assign outData = outQ;

  always_comb begin
    rdData = '0;
    if (strb.hit) begin
      if (strb.selIo) begin
        rdData[IN_BIT]  = syncB[pinSel];
        rdData[OUT_BIT] = outQ[pinSel];
      end else begin
        rdData[OE_BIT]                  = oeQ[pinSel];
        rdData[BIAS_LSB +: BIAS_W]      = biasQ[pinSel];
        rdData[DRV_LSB +: DRV_W]        = drvQ[pinSel];
        rdData[FUNC_LSB +: FUNC_W]      = funcQ[pinSel];
      end
    end
  end

  // R10: every field returns to its reset value one edge after reset
  p_reset_values_r10: assert property (@(posedge clk)
    rst |=> (outEn == '0 && outData == '0 && funcSel == '0 && driveCode == '0
             && biasSel == {NUM_PINS{BIAS_RESET}}));

  // R5: output enables move only on a control-word write
  p_oe_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !strb.wrCtl |=> $stable(outEn));

  // R6: output values move only on a data-word write
  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !strb.wrIo |=> $stable(outData));

  // R7: synchronized input lags the pad by two edges
  p_sync_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (syncB == $past(padIn, 2)));

  // R9: unmapped addresses read as zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.hit |-> (rdData == '0));
endmodule

// File: rtl/gpio_pad_regfile.sv
module gpio_pad_regfile
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wrEn,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  input  logic [NUM_PINS-1:0]       padIn,
  output logic [3*NUM_PINS-1:0]     funcSel,
  output logic [2*NUM_PINS-1:0]     biasSel,
  output logic [3*NUM_PINS-1:0]     driveCode,
  output logic [NUM_PINS-1:0]       outEn,
  output logic [NUM_PINS-1:0]       outData
);
  padStrobe_t strb;

  gpio_pad_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .wrEn (wrEn),
    .strb (strb)
  );

  gpio_pad_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .wrData    (wrData),
    .padIn     (padIn),
    .rdData    (rdData),
    .funcSel   (funcSel),
    .biasSel   (biasSel),
    .driveCode (driveCode),
    .outEn     (outEn),
    .outData   (outData)
  );
endmodule

// File: tb/gpio_pad_regfile_bench.sv
module gpio_pad_regfile_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [N-1:0] padIn = '0;
  logic [3*N-1:0] funcSel, driveCode;
  logic [2*N-1:0] biasSel;
  logic [N-1:0] outEn, outData;

  int checks = 0;
  int failures = 0;
  bit chkOn = 1'b0;
  bit done = 1'b0;

  int mFunc[N], mBias[N], mDrv[N], mOe[N], mOut[N], mS1[N], mS2[N];

  always #10 clk = ~clk;

  gpio_pad_regfile u_gpio_pad_regfile (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .funcSel(funcSel), .biasSel(biasSel),
    .driveCode(driveCode), .outEn(outEn), .outData(outData)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < N; p++) begin
        mFunc[p] = 0; mBias[p] = 1; mDrv[p] = 0; mOe[p] = 0; mOut[p] = 0;
        mS1[p] = 0; mS2[p] = 0;
      end
    end else begin
      int idx;
      for (int p = 0; p < N; p++) begin
        mS2[p] = mS1[p];
        mS1[p] = int'(padIn[p]);
      end
      idx = int'(addr) / 2;
      if (wrEn && idx < N) begin
        if (addr[0] == 1'b0) begin
          mFunc[idx] = int'(wrData[10:8]);
          mBias[idx] = int'(wrData[2:1]);
          mDrv[idx]  = int'(wrData[6:4]);
          mOe[idx]   = int'(wrData[0]);
        end else begin
          mOut[idx]  = int'(wrData[1]);
        end
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] a);
    int idx = int'(a) / 2;
    if (idx >= N) return 32'h0;
    if (a[0]) return 32'((mOut[idx] << 1) | mS2[idx]);
    return 32'((mFunc[idx] << 8) | (mDrv[idx] << 4) | (mBias[idx] << 1) | mOe[idx]);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (chkOn) begin
      logic [3*N-1:0] eF, eD;
      logic [2*N-1:0] eB;
      logic [N-1:0] eOe, eOut;
      for (int p = 0; p < N; p++) begin
        eF[3*p +: 3] = 3'(mFunc[p]);
        eD[3*p +: 3] = 3'(mDrv[p]);
        eB[2*p +: 2] = 2'(mBias[p]);
        eOe[p]  = mOe[p][0];
        eOut[p] = mOut[p][0];
      end
      check("R2 funcSel", 32'(funcSel), 32'(eF));
      check("R3 biasSel", 32'(biasSel), 32'(eB));
      check("R4 driveCode", 32'(driveCode), 32'(eD));
      check("R5 outEn", 32'(outEn), 32'(eOe));
      check("R6 outData", 32'(outData), 32'(eOut));
      check("R1 rdData", rdData, expRead(addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdAt(input logic [7:0] a);
    @(negedge clk);
    addr = a;
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [11:0] keepF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    chkOn = 1'b1;
    // R10 reset state
    check("R10 bias reset", 32'(biasSel), 32'h55);
    check("R10 oe reset", 32'(outEn), 32'h0);
    check("R10 func reset", 32'(funcSel), 32'h0);
    check("R10 drive reset", 32'(driveCode), 32'h0);
    rdAt(8'd0);
    check("R10 ctl read", rdData, 32'h2);

    // R1 R2 R3 R4 R5 full control write to pin 0
    wr(8'd0, 32'h577);
    #2;
    check("R2 func pin0", 32'(funcSel[2:0]), 32'd5);
    check("R3 bias pin0 pull-up", 32'(biasSel[1:0]), 32'd3);
    check("R4 drive 16mA", 32'((int'(driveCode[2:0]) + 1) * 2), 32'd16);
    check("R5 oe pin0", 32'(outEn[0]), 32'd1);
    check("R11 other pins func", 32'(funcSel[11:3]), 32'h0);
    check("R1 readback pin0", rdData, 32'h577);

    // R8 unused control bits
    wr(8'd0, 32'hFFFF_FFFF);
    #2;
    check("R8 ctl unused zero", rdData, 32'h777);

    // R6 R8 data word of pin 1
    wr(8'd3, 32'hFFFF_FFFF);
    #2;
    check("R6 outData pin1", 32'(outData[1]), 32'd1);
    check("R8 input bit ignored", rdData, 32'h2);

    // R7 synchronizer latency, output disabled
    @(negedge clk);
    padIn[1] = 1'b1; addr = 8'd3;
    @(negedge clk); #2;
    check("R7 one edge still old", 32'(rdData[0]), 32'd0);
    @(negedge clk); #2;
    check("R7 two edges new", 32'(rdData[0]), 32'd1);
    // R7 with output enabled
    wr(8'd2, 32'h1);
    @(negedge clk);
    padIn[1] = 1'b0; addr = 8'd3;
    @(negedge clk); @(negedge clk); #2;
    check("R7 input live with oe", 32'(rdData[0]), 32'd0);

    // R9 unmapped
    keepF = funcSel;
    wr(8'd8, 32'hFFFF_FFFF);
    wr(8'd200, 32'hFFFF_FFFF);
    rdAt(8'd8);
    check("R9 read addr 8", rdData, 32'h0);
    rdAt(8'd255);
    check("R9 read addr 255", rdData, 32'h0);
    check("R9 no state change", 32'(funcSel), 32'(keepF));

    // R3 bias sweep on pin 2
    for (int b = 0; b < 4; b++) begin
      wr(8'd4, 32'(b << 1));
      #2;
      check("R3 bias sweep", 32'(biasSel[5:4]), 32'(b));
    end
    // R4 drive sweep on pin 3
    for (int c = 0; c < 8; c++) begin
      wr(8'd6, 32'(c << 4));
      #2;
      check("R4 drive sweep mA", 32'((int'(driveCode[11:9]) + 1) * 2), 32'(2 + 2 * c));
      check("R11 pin0 kept", 32'(funcSel[2:0]), 32'd7);
    end

    // random traffic checked every cycle by the reference
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      addr   = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 10);
      wrEn   = ($urandom % 2) == 0;
      wrData = $urandom;
      padIn  = N'($urandom);
    end
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk); #3;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule